// File: doc/BRIEF.md
# Low-Power Watch State Controller

This controller sits beside a processor core. It decides when a sleep instruction sends the chip into a low-power watch state and how the chip comes back out. On a sleep strobe it checks three configuration bits and the operating mode it is tracking. If all of them allow it, the controller stops the CPU and every peripheral except the watchdog, and the watchdog's slow clock keeps running.

A permitted interrupt wakes the block. It then moves to a slow subclock mode, or it runs a programmable oscillator-settling wait and then goes to full or divided speed. When the chip is running again, a one-clock strobe tells the core to start interrupt handling. Two pins override everything else. The standby pin forces a hardware standby state. The reset pin returns the block to its reset state without any interrupt strobe.

Top module: `lpw_watch_ctrl`

## Requirements
- R1: With `sleep_req` high while the mode is high-speed (`clk_mode`=0) or subclock (`clk_mode`=2), and with `cfg_stby_sel`=1, `cfg_direct_xfer`=0 and `cfg_wdt_subclk`=1, `clk_mode` becomes 3 (watch) one cycle later.
- R2: A sleep strobe has no effect when any of those three bits differs from the values in R1, or when the mode is medium-speed (`clk_mode`=1). The mode stays unchanged.
- R3: While in watch (`clk_mode`=3), `cpu_stop`=1 and `periph_stop`=1, and `wdt_stop`=0.
- R4: In watch, these sources wake the block: `nmi_req` at any time, IRQ line i only when `irq_en[i]`=1, and `wdt_ovf_irq` only when `wdt_ovf_en`=1 and `cpu_int_mask`=0. Any other input pattern leaves the block in watch.
- R5: A wake with `cfg_low_speed`=1 gives `clk_mode`=2 (subclock) and `int_start`=1 one cycle later.
- R6: A wake with `cfg_low_speed`=0 starts a settling wait of 2^(SET_BASE+SET_STEP·n) cycles, where n is `cfg_settle_sel` at the wake (2^(4+n) with the default parameters). During the wait, `clk_mode` stays 3 and `cpu_stop`=1. The cycle after the wait ends, the mode is active and `int_start`=1.
- R7: At the end of settling, the mode is medium-speed (1) if the `cfg_clk_div` value captured at watch entry was nonzero, and high-speed (0) otherwise.
- R8: `int_start` is high for exactly one cycle per wake.
- R9: `stby_pin_n`=0 forces `clk_mode`=4 (hardware standby, `wdt_stop`=1) one cycle later, from any state. Interrupts do not release this state. It is left only through `res_pin_n`=0 while `stby_pin_n`=1, which leads to mode 0.
- R10: `res_pin_n`=0 (with `stby_pin_n`=1) gives `clk_mode`=0 with `int_start`=0 one cycle later. This takes priority over any simultaneous wake.
- R11: After `rst_n` reset, `clk_mode`=0 and `cpu_stop`, `periph_stop`, `wdt_stop` and `int_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_req | input | 1 | Sleep instruction strobe |
| cfg_stby_sel | input | 1 | Standby-select configuration bit |
| cfg_direct_xfer | input | 1 | Direct mode-transfer bit |
| cfg_wdt_subclk | input | 1 | Watchdog runs from the subclock |
| cfg_low_speed | input | 1 | Wake into subclock mode |
| cfg_settle_sel | input | 3 | Settling time select |
| cfg_clk_div | input | DIV_W | Clock divider field, captured at entry |
| irq_line | input | N_IRQ | External interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| nmi_req | input | 1 | Non-maskable interrupt |
| wdt_ovf_irq | input | 1 | Watchdog overflow interrupt |
| wdt_ovf_en | input | 1 | Watchdog interrupt enable |
| cpu_int_mask | input | 1 | CPU interrupt mask |
| res_pin_n | input | 1 | Reset pin, active low |
| stby_pin_n | input | 1 | Standby pin, active low |
| cpu_stop | output | 1 | CPU halted |
| periph_stop | output | 1 | Peripherals (not the watchdog) halted |
| wdt_stop | output | 1 | Watchdog halted |
| clk_mode | output | 3 | 0 high, 1 medium, 2 subclock, 3 watch or settling, 4 hardware standby |
| int_start | output | 1 | Interrupt handling start strobe |

## Verification
Every mode change and every stop output appears one cycle after the edge that samples the causing input, because the outputs decode the state register directly. `int_start` is registered and lands in that same cycle. After an interrupt wake to full speed, the active mode and the strobe are due exactly 2^(4+n) edges after the wake edge. The bench drives inputs at the falling edge and samples at the next falling edge. For settling, it counts the edges and checks both the last waiting cycle and the first active cycle, then the cycle after to confirm the strobe has dropped.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [2:0] {
    S_HIGH, S_MED, S_SUB, S_WATCH, S_SETTLE, S_HWSTBY
  } st_e;

  typedef enum logic [2:0] {
    MD_HIGH  = 3'd0,
    MD_MED   = 3'd1,
    MD_SUB   = 3'd2,
    MD_WATCH = 3'd3,
    MD_STBY  = 3'd4
  } mode_e;

  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;
endpackage

// File: rtl/lpw_wake_arb.sv
module lpw_wake_arb #(
  parameter int N_IRQ = 6
) (
  input  logic [N_IRQ-1:0] irq_line,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             nmi_req,
  input  logic             wdt_ovf_irq,
  input  logic             wdt_ovf_en,
  input  logic             cpu_int_mask,
  output logic             wake
);
  logic [N_IRQ-1:0] line_hit;
  logic             wdt_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign line_hit[i] = irq_line[i] & irq_en[i];
  end

  assign wdt_hit = wdt_ovf_irq & wdt_ovf_en & ~cpu_int_mask;
  assign wake    = nmi_req | (|line_hit) | wdt_hit;

  // R4: a lone masked watchdog request never wakes
  always_comb begin
    if (!nmi_req && line_hit == '0 && cpu_int_mask)
      a_mask_blocks_r4: assert (!wake);
  end
endmodule

// File: rtl/lpw_settle_timer.sv
module lpw_settle_timer
  import lpw_pkg::*;
#(
  parameter int SET_BASE = 4,
  parameter int SET_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int CNT_W = SET_BASE + SET_STEP * (NUM_SEL - 1) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;
  logic [SEL_W-1:0] sel_q;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = start | run;
    if (start)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb
    last_cnt = (CNT_W'(1) << (SET_BASE + SET_STEP * int'(sel_q))) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (start)  sel_q <= sel;
    end
  end

  assign done = run && (cnt_q == last_cnt);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_cnt));
endmodule

// File: rtl/lpw_watch_ctrl.sv
module lpw_watch_ctrl
  import lpw_pkg::*;
#(
  parameter int N_IRQ    = 6,
  parameter int DIV_W    = 2,
  parameter int SET_BASE = 4,
  parameter int SET_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             cfg_stby_sel,
  input  logic             cfg_direct_xfer,
  input  logic             cfg_wdt_subclk,
  input  logic             cfg_low_speed,
  input  logic [2:0]       cfg_settle_sel,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic [N_IRQ-1:0] irq_line,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             nmi_req,
  input  logic             wdt_ovf_irq,
  input  logic             wdt_ovf_en,
  input  logic             cpu_int_mask,
  input  logic             res_pin_n,
  input  logic             stby_pin_n,
  output logic             cpu_stop,
  output logic             periph_stop,
  output logic             wdt_stop,
  output logic [2:0]       clk_mode,
  output logic             int_start
);
  st_e              st_q, st_d;
  logic [DIV_W-1:0] div_q;
  logic             div_load, strobe_d, int_start_q;
  logic             wake, entry_ok, settle_start, settle_done;
  mode_e            mode;

  lpw_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .irq_line     (irq_line),
    .irq_en       (irq_en),
    .nmi_req      (nmi_req),
    .wdt_ovf_irq  (wdt_ovf_irq),
    .wdt_ovf_en   (wdt_ovf_en),
    .cpu_int_mask (cpu_int_mask),
    .wake         (wake)
  );

  lpw_settle_timer #(.SET_BASE(SET_BASE), .SET_STEP(SET_STEP)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .run   (st_q == S_SETTLE),
    .sel   (cfg_settle_sel),
    .done  (settle_done)
  );

  assign entry_ok = cfg_stby_sel & ~cfg_direct_xfer & cfg_wdt_subclk;

  // next state: standby pin, then reset pin, then normal flow
  always_comb begin
    st_d         = st_q;
    strobe_d     = 1'b0;
    settle_start = 1'b0;
    div_load     = 1'b0;
    if (!stby_pin_n) begin
      st_d = S_HWSTBY;
    end else if (!res_pin_n) begin
      st_d = S_HIGH;
    end else begin
      unique case (st_q)
        S_HIGH, S_SUB: begin
          if (sleep_req && entry_ok) begin
            st_d     = S_WATCH;
            div_load = 1'b1;
          end
        end
        S_WATCH: begin
          if (wake) begin
            if (cfg_low_speed) begin
              st_d     = S_SUB;
              strobe_d = 1'b1;
            end else begin
              st_d         = S_SETTLE;
              settle_start = 1'b1;
            end
          end
        end
        S_SETTLE: begin
          if (settle_done) begin
            st_d     = (div_q != '0) ? S_MED : S_HIGH;
            strobe_d = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_HIGH;
      div_q       <= '0;
      int_start_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      int_start_q <= strobe_d;
      if (div_load) div_q <= cfg_clk_div;
    end
  end

  always_comb begin
    unique case (st_q)
      S_MED:             mode = MD_MED;
      S_SUB:             mode = MD_SUB;
      S_WATCH, S_SETTLE: mode = MD_WATCH;
      S_HWSTBY:          mode = MD_STBY;
      default:           mode = MD_HIGH;
    endcase
  end

  assign clk_mode    = mode;
  assign cpu_stop    = (st_q == S_WATCH) || (st_q == S_SETTLE) || (st_q == S_HWSTBY);
  assign periph_stop = cpu_stop;
  assign wdt_stop    = (st_q == S_HWSTBY);
  assign int_start   = int_start_q;

  p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_pin_n && res_pin_n && sleep_req && entry_ok &&
     (clk_mode == MD_HIGH || clk_mode == MD_SUB)) |=> (clk_mode == MD_WATCH));
  p_watch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_pin_n && res_pin_n && st_q == S_WATCH && !wake) |=> (st_q == S_WATCH));
  p_sub_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_pin_n && res_pin_n && st_q == S_WATCH && wake && cfg_low_speed)
    |=> (clk_mode == MD_SUB && int_start));
  p_settle_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_pin_n && res_pin_n && st_q == S_SETTLE && settle_done)
    |=> (clk_mode == ((div_q != '0) ? MD_MED : MD_HIGH)));
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_start |=> !int_start);
  p_stby_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_pin_n |=> (clk_mode == MD_STBY && wdt_stop));
  p_reset_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_pin_n && !res_pin_n) |=> (clk_mode == MD_HIGH && !int_start));
endmodule

// File: tb/lpw_watch_ctrl_test.sv
`timescale 1ns/1ps
module lpw_watch_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n, sleep_req, cfg_stby_sel, cfg_direct_xfer, cfg_wdt_subclk;
  logic       cfg_low_speed, nmi_req, wdt_ovf_irq, wdt_ovf_en, cpu_int_mask;
  logic       res_pin_n, stby_pin_n;
  logic [2:0] cfg_settle_sel;
  logic [1:0] cfg_clk_div;
  logic [5:0] irq_line, irq_en;
  logic       cpu_stop, periph_stop, wdt_stop, int_start;
  logic [2:0] clk_mode;
  int checks = 0;
  int errors = 0;

  // [16:11] irq_line, [10:5] irq_en, [4] nmi, [3] wdt, [2] wdt_en, [1] mask, [0] expect wake
  localparam logic [16:0] WVEC [8] = '{
    {6'b000001, 6'b000001, 5'b00001},
    {6'b100000, 6'b011111, 5'b00000},
    {6'b100000, 6'b100000, 5'b00001},
    {6'b000000, 6'b111111, 5'b10001},
    {6'b000000, 6'b000000, 5'b01101},
    {6'b000000, 6'b000000, 5'b01110},
    {6'b000000, 6'b000000, 5'b01000},
    {6'b010100, 6'b101011, 5'b00010}
  };

  always #2.5 clk = ~clk;

  lpw_watch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cfg_stby_sel(cfg_stby_sel),
    .cfg_direct_xfer(cfg_direct_xfer), .cfg_wdt_subclk(cfg_wdt_subclk),
    .cfg_low_speed(cfg_low_speed), .cfg_settle_sel(cfg_settle_sel),
    .cfg_clk_div(cfg_clk_div), .irq_line(irq_line), .irq_en(irq_en),
    .nmi_req(nmi_req), .wdt_ovf_irq(wdt_ovf_irq), .wdt_ovf_en(wdt_ovf_en),
    .cpu_int_mask(cpu_int_mask), .res_pin_n(res_pin_n), .stby_pin_n(stby_pin_n),
    .cpu_stop(cpu_stop), .periph_stop(periph_stop), .wdt_stop(wdt_stop),
    .clk_mode(clk_mode), .int_start(int_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clear_src();
    irq_line = '0; irq_en = '0; nmi_req = 0;
    wdt_ovf_irq = 0; wdt_ovf_en = 0; cpu_int_mask = 0;
  endtask

  task automatic go_high();
    res_pin_n = 0; step(); res_pin_n = 1;
  endtask

  task automatic enter_watch(input logic [1:0] div);
    cfg_stby_sel = 1; cfg_direct_xfer = 0; cfg_wdt_subclk = 1; cfg_clk_div = div;
    sleep_req = 1; step(); sleep_req = 0;
  endtask

  task automatic settle_run(input int sel, input int exp_mode, input string tag);
    int term;
    term = 1 << (4 + sel);
    cfg_low_speed = 0; cfg_settle_sel = 3'(sel);
    nmi_req = 1; step(); nmi_req = 0;
    step(term - 1);
    chk({tag, " still settling"}, clk_mode, 3);
    chk({tag, " cpu held"}, cpu_stop, 1);
    chk({tag, " no early strobe"}, int_start, 0);
    step();
    chk({tag, " mode after wait"}, clk_mode, exp_mode);
    chk({tag, " strobe"}, int_start, 1);
    step();
    chk("R8 strobe drops", int_start, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; sleep_req = 0; cfg_stby_sel = 0; cfg_direct_xfer = 0; cfg_wdt_subclk = 0;
    cfg_low_speed = 1; cfg_settle_sel = 0; cfg_clk_div = 0;
    res_pin_n = 1; stby_pin_n = 1;
    clear_src();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R11 mode", clk_mode, 0);
    chk("R11 cpu_stop", cpu_stop, 0);
    chk("R11 periph_stop", periph_stop, 0);
    chk("R11 wdt_stop", wdt_stop, 0);
    chk("R11 int_start", int_start, 0);

    // wake source table, low-speed wake target
    for (int i = 0; i < 8; i++) begin
      go_high(); enter_watch(0);
      cfg_low_speed = 1;
      {irq_line, irq_en, nmi_req, wdt_ovf_irq, wdt_ovf_en, cpu_int_mask} = WVEC[i][16:1];
      step();
      clear_src();
      chk("R4 R5 wake mode", clk_mode, WVEC[i][0] ? 2 : 3);
      chk("R5 wake strobe", int_start, WVEC[i][0] ? 1 : 0);
    end

    // R2: entry conditions not met, and from medium
    go_high();
    cfg_stby_sel = 1; cfg_direct_xfer = 1; cfg_wdt_subclk = 1; sleep_req = 1; step(); sleep_req = 0;
    chk("R2 direct bit set", clk_mode, 0);
    cfg_stby_sel = 0; cfg_direct_xfer = 0; sleep_req = 1; step(); sleep_req = 0;
    chk("R2 standby bit clear", clk_mode, 0);
    cfg_stby_sel = 1; cfg_wdt_subclk = 0; sleep_req = 1; step(); sleep_req = 0;
    chk("R2 wdt clock bit clear", clk_mode, 0);
    chk("R2 cpu running", cpu_stop, 0);

    // R1 and R3
    enter_watch(0);
    chk("R1 entry from high", clk_mode, 3);
    chk("R3 cpu_stop", cpu_stop, 1);
    chk("R3 periph_stop", periph_stop, 1);
    chk("R3 wdt runs", wdt_stop, 0);
    cfg_low_speed = 1; nmi_req = 1; step(); nmi_req = 0; step();
    chk("R5 in subclock", clk_mode, 2);
    enter_watch(0);
    chk("R1 entry from subclock", clk_mode, 3);

    // R6 settling, two lengths
    go_high(); enter_watch(0);
    settle_run(0, 0, "R6 n0");
    enter_watch(0);
    settle_run(2, 0, "R6 n2");

    // R7 medium target, divider captured at entry
    enter_watch(2);
    cfg_clk_div = 0;
    settle_run(0, 1, "R7 medium");
    enter_watch(0);
    chk("R2 sleep ignored in medium", clk_mode, 1);

    // R9 standby
    go_high();
    stby_pin_n = 0; step();
    chk("R9 standby from active", clk_mode, 4);
    chk("R9 wdt stopped", wdt_stop, 1);
    stby_pin_n = 1; go_high(); enter_watch(0);
    stby_pin_n = 0; step(); stby_pin_n = 1; step();
    chk("R9 standby held", clk_mode, 4);
    nmi_req = 1; step(); nmi_req = 0;
    chk("R9 interrupt ignored", clk_mode, 4);
    res_pin_n = 0; step(); res_pin_n = 1;
    chk("R9 reset exit", clk_mode, 0);

    // R10 reset pin beats simultaneous wake
    enter_watch(0);
    cfg_low_speed = 1; nmi_req = 1; res_pin_n = 0; step();
    nmi_req = 0; res_pin_n = 1;
    chk("R10 mode", clk_mode, 0);
    chk("R10 no strobe", int_start, 0);
    enter_watch(0);
    cfg_low_speed = 0; nmi_req = 1; step(); nmi_req = 0; step(3);
    res_pin_n = 0; step(); res_pin_n = 1;
    chk("R10 abort settling", clk_mode, 0);
    step(20);
    chk("R10 no late strobe", int_start, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule